// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is a general-purpose up-counting timer with one pulse-width-modulated output. A programmable prescaler divides the input clock. The divided ticks advance a main counter, which runs from zero up to a reload limit and then wraps to zero. A compare value sets the point in each period where the output reference goes from high to low. The reference reaches the output pin only when the channel is configured as an output and its enable bit is set.

Software configures the timer through a synchronous write port with an address, write data and a write strobe. A combinational read port returns the register addressed on the same bus. The prescale and reload registers are preload registers. The counting logic uses shadow copies of them, and those copies change only on an update event. An update event is either a software update request or the main counter wrapping by itself. A software update also restarts both counters at zero.

The counting engine is a two-state machine. In `ST_HALT` the counters hold their values. In `ST_RUN` they advance. The transition `halt_to_run` is taken when the enable bit is set, and `run_to_halt` is taken when it is cleared. A software update overrides both states in the cycle it is seen. The output stage is pure combinational gating of the counter against the compare value.

Register map (32-bit data). The offsets are part of the behaviour the requirements rely on:
- 0 enable: bit 0 enables counting.
- 1 update request: bit 0, self-clearing.
- 2 channel mode: bits [1:0] select the channel function, bits [4:2] select the compare mode.
- 3 output enable: bit 0.
- 4 prescale preload.
- 5 reload preload.
- 6 compare value.
- 7 live counter, read-only.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero except the reload preload at offset 5, which reads 0xFFFFFFFF. The pin `pwm_o` is low.
- R2: The counter steps from 0 up to the active reload value inclusive and then returns to 0. The output period is (prescale+1)×(reload+1) clocks.
- R3: The prescaler steps from 0 up to the active prescale value inclusive. The counter advances once every prescale+1 clocks.
- R4: With compare mode code 3'b110 (bits [4:2] of offset 2), the reference is high while the counter is below the compare value and low otherwise. A compare of 0 gives a constant low, and a compare above the reload value gives a constant high.
- R5: Counting happens only while bit 0 of offset 0 is set. While it is clear, the counter holds its value.
- R6: Writing 1 to bit 0 of offset 1 restarts the prescaler and the counter at 0 and copies the preloads into the shadows. This bit reads 1 for one cycle and then 0.
- R7: Writes to offsets 4 and 5 do not change counting until the next update event, which is either a software update or a natural wrap of the counter.
- R8: The pin is driven only when the select bits [1:0] of offset 2 are 2'b00 and bit 0 of offset 3 is set. Otherwise the pin is low.
- R9: Any compare mode code other than 3'b110 holds the reference low.
- R10: Offset 7 returns the live counter value, and writes to offset 7 are ignored. All other offsets read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register offset, used for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| pwm_o | output | 1 | Gated PWM output pin |

## Verification
The bench goes after the shadow behaviour first. It programs a short reload value without requesting an update and checks that the counter runs past that value; a design that applied the preload at once would wrap early. It then changes the prescale and reload values while the timer runs and checks the period only after a natural wrap, which catches a design that never reloads its shadows on overflow. The duty-cycle extremes (compare of zero, compare above reload) expose an off-by-one in the comparison. Non-PWM mode codes, a non-output select and a cleared output enable must each hold the pin low, and a leaky gate would show pulses there.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef logic [2:0] reg_addr_t;

    localparam reg_addr_t OFF_ENABLE = 3'd0;
    localparam reg_addr_t OFF_UPDATE = 3'd1;
    localparam reg_addr_t OFF_MODE   = 3'd2;
    localparam reg_addr_t OFF_OE     = 3'd3;
    localparam reg_addr_t OFF_PSC    = 3'd4;
    localparam reg_addr_t OFF_ARR    = 3'd5;
    localparam reg_addr_t OFF_CMP    = 3'd6;
    localparam reg_addr_t OFF_COUNT  = 3'd7;

    localparam logic [2:0] MODE_PWM_LOW_AFTER = 3'b110;
    localparam logic [1:0] SEL_OUTPUT         = 2'b00;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_addr_t     addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  count_i,
    output logic [W-1:0]  rdata,
    output logic          run_o,
    output logic          upd_o,
    output logic [1:0]    sel_o,
    output logic [2:0]    mode_o,
    output logic          oe_o,
    output logic [W-1:0]  psc_pre_o,
    output logic [W-1:0]  arr_pre_o,
    output logic [W-1:0]  cmp_o
);
    localparam int MODE_BITS = 5;

    logic [MODE_BITS-1:0] mode_q;
    logic                 run_q, upd_q, oe_q;
    logic [W-1:0]         psc_q, arr_q, cmp_q;
    logic                 upd_write;

    assign upd_write = wr_en && (addr == OFF_UPDATE) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            upd_q  <= 1'b0;
            mode_q <= '0;
            oe_q   <= 1'b0;
            psc_q  <= '0;
            arr_q  <= '1;
            cmp_q  <= '0;
        end else begin
            upd_q <= upd_write;
            if (wr_en) begin
                unique case (addr)
                    OFF_ENABLE: run_q  <= wdata[0];
                    OFF_MODE:   mode_q <= wdata[MODE_BITS-1:0];
                    OFF_OE:     oe_q   <= wdata[0];
                    OFF_PSC:    psc_q  <= wdata;
                    OFF_ARR:    arr_q  <= wdata;
                    OFF_CMP:    cmp_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFF_ENABLE: rdata = {{(W-1){1'b0}}, run_q};
            OFF_UPDATE: rdata = {{(W-1){1'b0}}, upd_q};
            OFF_MODE:   rdata = {{(W-MODE_BITS){1'b0}}, mode_q};
            OFF_OE:     rdata = {{(W-1){1'b0}}, oe_q};
            OFF_PSC:    rdata = psc_q;
            OFF_ARR:    rdata = arr_q;
            OFF_CMP:    rdata = cmp_q;
            default:    rdata = count_i;
        endcase
    end

    assign run_o     = run_q;
    assign upd_o     = upd_q;
    assign sel_o     = mode_q[1:0];
    assign mode_o    = mode_q[4:2];
    assign oe_o      = oe_q;
    assign psc_pre_o = psc_q;
    assign arr_pre_o = arr_q;
    assign cmp_o     = cmp_q;

    // R6: the update request lasts one cycle unless it is written again
    assert_update_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && !upd_write) |=> !upd_q);
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
    import pwm_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         upd_i,
    input  logic [W-1:0] psc_pre_i,
    input  logic [W-1:0] arr_pre_i,
    output logic [W-1:0] count_o
);
    run_state_t   state_q, state_d;
    logic [W-1:0] div_q, div_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] psc_sh_q, psc_sh_d;
    logic [W-1:0] arr_sh_q, arr_sh_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HALT;
            div_q    <= '0;
            cnt_q    <= '0;
            psc_sh_q <= '0;
            arr_sh_q <= '1;
        end else begin
            state_q  <= state_d;
            div_q    <= div_d;
            cnt_q    <= cnt_d;
            psc_sh_q <= psc_sh_d;
            arr_sh_q <= arr_sh_d;
        end
    end

    // transitions and counting
    always_comb begin
        state_d  = state_q;
        div_d    = div_q;
        cnt_d    = cnt_q;
        psc_sh_d = psc_sh_q;
        arr_sh_d = arr_sh_q;
        unique case (state_q)
            ST_HALT: if (run_i)  state_d = ST_RUN;   // halt_to_run
            ST_RUN:  if (!run_i) state_d = ST_HALT;  // run_to_halt
            default: state_d = ST_HALT;
        endcase
        if (upd_i) begin
            div_d    = '0;
            cnt_d    = '0;
            psc_sh_d = psc_pre_i;
            arr_sh_d = arr_pre_i;
        end else if (state_q == ST_RUN) begin
            if (div_q >= psc_sh_q) begin
                div_d = '0;
                if (cnt_q >= arr_sh_q) begin
                    cnt_d    = '0;
                    psc_sh_d = psc_pre_i;
                    arr_sh_d = arr_pre_i;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                div_d = div_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;

    assert_cnt_within_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= arr_sh_q);
    assert_div_within_prescale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= psc_sh_q);
    assert_hold_when_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !upd_i) |=> $stable(cnt_q));
    assert_update_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (cnt_q == '0 && div_q == '0));
endmodule

// File: rtl/pwm_timer_out.sv
module pwm_timer_out
    import pwm_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] cmp_i,
    input  logic [2:0]   mode_i,
    input  logic [1:0]   sel_i,
    input  logic         oe_i,
    output logic         pin_o
);
    logic ref_lvl;

    always_comb begin
        ref_lvl = (mode_i == MODE_PWM_LOW_AFTER) && (count_i < cmp_i);
        pin_o   = ref_lvl && (sel_i == SEL_OUTPUT) && oe_i;
    end

    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_o |-> (sel_i == SEL_OUTPUT && oe_i));
    assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_PWM_LOW_AFTER) |-> !pin_o);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         pwm_o
);
    logic         run, upd, oe;
    logic [1:0]   sel;
    logic [2:0]   mode;
    logic [W-1:0] psc_pre, arr_pre, cmp, count;

    pwm_timer_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_i(count), .rdata(rdata), .run_o(run), .upd_o(upd),
        .sel_o(sel), .mode_o(mode), .oe_o(oe), .psc_pre_o(psc_pre),
        .arr_pre_o(arr_pre), .cmp_o(cmp)
    );

    pwm_timer_core #(.W(W)) core_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .upd_i(upd),
        .psc_pre_i(psc_pre), .arr_pre_i(arr_pre), .count_o(count)
    );

    pwm_timer_out #(.W(W)) out_i (
        .clk(clk), .rst_n(rst_n), .count_i(count), .cmp_i(cmp),
        .mode_i(mode), .sel_i(sel), .oe_i(oe), .pin_o(pwm_o)
    );
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    localparam logic [31:0] MODE_PWM = 32'b110_00;

    always #5 clk = ~clk;

    pwm_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int period, output int high);
        logic prev;
        int   guard;
        period = 0; high = 0; guard = 0;
        @(negedge clk); prev = pwm_o;
        while (!(prev == 1'b0 && pwm_o == 1'b1) && guard < 500) begin
            prev = pwm_o; @(negedge clk); guard++;
        end
        do begin
            if (pwm_o) high++;
            period++;
            prev = pwm_o; @(negedge clk);
        end while (!(prev == 1'b0 && pwm_o == 1'b1) && period < 500);
    endtask

    task automatic level_for(input string req, input int n, input logic lvl);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o !== lvl) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 reset value", v, (a == 5) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("R1 pin low", {31'b0, pwm_o}, 32'h0);
    endtask

    task automatic t_preload_wait;
        logic [31:0] v;
        wr(3'd4, 32'd6); wr(3'd5, 32'd5); wr(3'd6, 32'd3);
        wr(3'd2, MODE_PWM); wr(3'd3, 32'd1); wr(3'd0, 32'd1);
        idle(20);
        rd(3'd7, v);
        check("R7 reload preload not yet active", {31'b0, (v >= 32'd10)}, 32'd1);
        wr(3'd7, 32'd0);
        rd(3'd7, v);
        check("R10 count offset read-only", {31'b0, (v >= 32'd10)}, 32'd1);
    endtask

    task automatic t_update;
        logic [31:0] v;
        wr(3'd1, 32'd1);
        rd(3'd1, v);
        check("R6 update bit visible", v, 32'd1);
        idle(1);
        rd(3'd1, v);
        check("R6 update bit self-clears", v, 32'd0);
        rd(3'd7, v);
        check("R6 counter restarted", v, 32'd0);
    endtask

    task automatic t_period(input string req, input int exp_p, input int exp_h);
        int p, h;
        measure(p, h);
        check({req, " period"}, p, exp_p);
        check({req, " high time"}, h, exp_h);
    endtask

    task automatic t_halt;
        logic [31:0] a, b;
        wr(3'd0, 32'd0);
        rd(3'd7, a);
        idle(15);
        rd(3'd7, b);
        check("R5 counter holds while disabled", b, a);
        wr(3'd0, 32'd1);
    endtask

    task automatic t_extremes;
        wr(3'd6, 32'd0);  level_for("R4 compare zero low", 60, 1'b0);
        wr(3'd6, 32'd7);  level_for("R4 compare above reload high", 60, 1'b1);
        wr(3'd6, 32'd3);
    endtask

    task automatic t_gating;
        wr(3'd2, 32'b001_00); level_for("R9 other mode code low", 60, 1'b0);
        wr(3'd2, 32'b111_00); level_for("R9 mode 111 low", 60, 1'b0);
        wr(3'd2, MODE_PWM | 32'd1); level_for("R8 select not output low", 60, 1'b0);
        wr(3'd2, MODE_PWM);
        wr(3'd3, 32'd0); level_for("R8 output disabled low", 60, 1'b0);
        wr(3'd3, 32'd1);
    endtask

    task automatic t_natural_wrap;
        wr(3'd4, 32'd0); wr(3'd5, 32'd9); wr(3'd6, 32'd5);
        idle(100);
        t_period("R7 shadows loaded at wrap", 10, 5);
    endtask

    task automatic t_fast;
        wr(3'd5, 32'd1); wr(3'd6, 32'd1); wr(3'd1, 32'd1);
        idle(3);
        t_period("R2 R3 minimum period", 2, 1);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_preload_wait();
        t_update();
        t_period("R2 R3 R4 prescaled square wave", 42, 21);
        t_halt();
        t_period("R5 resumes after re-enable", 42, 21);
        t_extremes();
        t_gating();
        t_period("R8 restored output", 42, 21);
        t_natural_wrap();
        t_fast();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule